// File: doc/BRIEF.md
# ADC Result Buffer with Conversion-Count Interrupt

This block sits behind a successive-approximation converter and holds its results. Each incoming 10-bit code is turned into a 16-bit word in one of four justification formats in the same cycle it is written. The word then goes into a 16-entry store that the processor side can only read, through a random-access port. The block counts the results that arrive and raises a sticky interrupt flag after a programmed number of them. When the flag is raised, the fill position returns to the start of its region, so software always finds a batch starting at a known address.

There are two fill modes. In single mode the whole store is one region of sixteen words. In split mode it is two halves of eight words. The converter fills one half while software reads the other, and the halves swap at every interrupt. A status output reports which half is currently being filled.

Top module: `adc_result_buffer`

## Requirements
- R1: After reset every location reads 0x0000, the interrupt flag is 0, the fill-half status is 0 and the next write goes to location 0.
- R2: Format code 0 stores the code unsigned and right-justified in bits 9:0, with bits 15:10 zero.
- R3: Format code 1 stores a right-justified signed value: code bit 9 is inverted (mid-scale 0x200 becomes zero) and the result is sign-extended through bit 15.
- R4: Format code 2 stores the code unsigned and left-justified in bits 15:6, with bits 5:0 zero.
- R5: Format code 3 stores the code left-justified in bits 15:6 with bit 9 inverted, and bits 5:0 zero.
- R6: With count setting N (0..15), the interrupt event happens on the (N+1)th accepted result after reset or after the previous event, in the same cycle that result is written.
- R7: In single mode, results go to consecutive locations starting at 0 and wrap at 15. After each interrupt event the next result goes to location 0.
- R8: In split mode, the fill half toggles at each interrupt event and the next write goes to the base of the new half (0 or 8). The fill-half status output is 1 while the upper half (8..15) fills and 0 otherwise. In single mode it reads 0.
- R9: In split mode, a count larger than eight wraps the write position inside the current half and never reaches the other half.
- R10: The interrupt flag stays set until the clear input is asserted. An event in the same cycle as a clear leaves the flag set.
- R11: A cycle without a valid result changes no stored word, no count and no write position, whatever the data input carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_valid | input | 1 | A new conversion result is present this cycle |
| res_code | input | 10 | Raw unipolar conversion code |
| fmt_sel | input | 2 | Output format: 0 uint, 1 sint, 2 ufrac, 3 sfrac |
| seq_per_irq | input | 4 | Count setting N; interrupt after N+1 results |
| split_mode | input | 1 | 1 = two 8-word halves, 0 = one 16-word region |
| irq_clear | input | 1 | Clears the interrupt flag |
| rd_addr | input | 4 | Read location |
| rd_data | output | 16 | Formatted word at rd_addr (combinational read) |
| fill_upper | output | 1 | Split mode: upper half is filling |
| irq_flag | output | 1 | Sticky interrupt flag |

## Verification
The bench uses the default parameters: 10-bit codes, 16-bit words and a 16-entry store. With these, every count setting from 1 to 16 results can be run to completion, and both halves of the split mode are filled and swapped several times. At this depth a split-mode count above eight actually wraps inside a half, so R9 is exercised. Random segments change format, mode and count between batches, and the bench reads all sixteen locations after each step.

// File: rtl/adc_buf_pkg.sv
package adc_buf_pkg;
    typedef enum logic [1:0] {
        FMT_UINT  = 2'd0,
        FMT_SINT  = 2'd1,
        FMT_UFRAC = 2'd2,
        FMT_SFRAC = 2'd3
    } fmt_e;
endpackage

// File: rtl/adc_word_fmt.sv
module adc_word_fmt #(
    parameter int RAW_W = 10,
    parameter int OUT_W = 16
) (
    input  logic [RAW_W-1:0] code_i,
    input  logic [1:0]       fmt_i,
    output logic [OUT_W-1:0] word_o
);
    import adc_buf_pkg::*;
    localparam int PAD = OUT_W - RAW_W;

    logic [RAW_W-1:0] offs;   // unipolar code with top bit flipped: two's complement

    always_comb begin
        offs = {~code_i[RAW_W-1], code_i[RAW_W-2:0]};
        unique case (fmt_e'(fmt_i))
            FMT_UINT:  word_o = {{PAD{1'b0}}, code_i};
            FMT_SINT:  word_o = {{PAD{offs[RAW_W-1]}}, offs};
            FMT_UFRAC: word_o = {code_i, {PAD{1'b0}}};
            default:   word_o = {offs, {PAD{1'b0}}};
        endcase
    end

    always_comb begin
        if (fmt_i == 2'd0) a_uint_top_r2: assert (word_o[OUT_W-1:RAW_W] == '0);
        if (fmt_i[1])      a_frac_low_r4: assert (word_o[PAD-1:0] == '0);
    end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          res_valid,
    input  logic [AW-1:0] seq_per_irq,
    input  logic          split_mode,
    input  logic          irq_clear,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic          fill_upper,
    output logic          irq_flag
);
    localparam int OW = AW - 1;   // offset width inside one half

    typedef struct packed {
        logic [AW-1:0] ptr;
        logic [AW-1:0] cnt;
        logic          half;
        logic          flag;
    } st_t;

    st_t  st_d, st_q;
    logic evt;

    always_comb begin
        st_d = st_q;
        evt  = 1'b0;
        if (res_valid) begin
            if (st_q.cnt >= seq_per_irq) begin
                evt      = 1'b1;
                st_d.cnt = '0;
                if (split_mode) begin
                    st_d.half = ~st_q.half;
                    st_d.ptr  = {~st_q.half, {OW{1'b0}}};
                end else begin
                    st_d.half = 1'b0;
                    st_d.ptr  = '0;
                end
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
                if (split_mode)
                    st_d.ptr = {st_q.ptr[AW-1], st_q.ptr[OW-1:0] + 1'b1};
                else
                    st_d.ptr = st_q.ptr + 1'b1;
            end
        end
        if (evt)            st_d.flag = 1'b1;
        else if (irq_clear) st_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_en      = res_valid;
    assign wr_addr    = split_mode ? {st_q.half, st_q.ptr[OW-1:0]} : st_q.ptr;
    assign fill_upper = split_mode & st_q.half;
    assign irq_flag   = st_q.flag;

    p_flag_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_flag && !irq_clear |=> irq_flag);
    p_flag_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_clear && !evt |=> !irq_flag);
    p_single_base_r7: assert property (@(posedge clk) disable iff (!rst_n)
        evt && !split_mode |=> st_q.ptr == '0);
    p_half_swap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        evt && split_mode |=> st_q.half != $past(st_q.half) && st_q.ptr[OW-1:0] == '0);
    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |=> $stable(st_q.ptr) && $stable(st_q.cnt));
    p_evt_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> irq_flag);
endmodule

// File: rtl/adc_res_store.sv
module adc_res_store #(
    parameter int DEPTH = 16,
    parameter int W     = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [DEPTH-1:0][W-1:0] mem_d, mem_q;

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        assign mem_d[i] = (we && waddr == AW'(i)) ? wdata : mem_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    assign rdata = mem_q[raddr];

    p_no_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(mem_q));
    p_one_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> mem_q[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/adc_result_buffer.sv
module adc_result_buffer #(
    parameter int RAW_W = 10,
    parameter int OUT_W = 16,
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             res_valid,
    input  logic [RAW_W-1:0] res_code,
    input  logic [1:0]       fmt_sel,
    input  logic [AW-1:0]    seq_per_irq,
    input  logic             split_mode,
    input  logic             irq_clear,
    input  logic [AW-1:0]    rd_addr,
    output logic [OUT_W-1:0] rd_data,
    output logic             fill_upper,
    output logic             irq_flag
);
    logic             wr_en;
    logic [AW-1:0]    wr_addr;
    logic [OUT_W-1:0] wr_word;

    adc_word_fmt #(.RAW_W(RAW_W), .OUT_W(OUT_W)) u_fmt (
        .code_i (res_code),
        .fmt_i  (fmt_sel),
        .word_o (wr_word)
    );

    adc_seq_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .res_valid   (res_valid),
        .seq_per_irq (seq_per_irq),
        .split_mode  (split_mode),
        .irq_clear   (irq_clear),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .fill_upper  (fill_upper),
        .irq_flag    (irq_flag)
    );

    adc_res_store #(.DEPTH(DEPTH), .W(OUT_W), .AW(AW)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en),
        .waddr (wr_addr),
        .wdata (wr_word),
        .raddr (rd_addr),
        .rdata (rd_data)
    );
endmodule

// File: tb/sim_adc_result_buffer.sv
`timescale 1ns/10ps
module sim_adc_result_buffer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        res_valid = 1'b0;
    logic [9:0]  res_code = '0;
    logic [1:0]  fmt_sel = '0;
    logic [3:0]  seq_per_irq = '0;
    logic        split_mode = 1'b0;
    logic        irq_clear = 1'b0;
    logic [3:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        fill_upper, irq_flag;

    always #2.5 clk = ~clk;

    adc_result_buffer u0 (.*);

    int checks = 0, errors = 0;
    bit finished = 0;
    logic [15:0] em [16];
    int  ep = 0, ec = 0;
    bit  eh = 0, ef = 0;

    function automatic logic [15:0] fmtw(logic [9:0] c, logic [1:0] f);
        logic [9:0] s;
        s = {~c[9], c[8:0]};
        case (f)
            2'd0: return {6'd0, c};
            2'd1: return {{6{s[9]}}, s};
            2'd2: return {c, 6'd0};
            default: return {s, 6'd0};
        endcase
    endfunction

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Called just after a negedge: read every location and the flags.
    task automatic chk_all(string req);
        check(req, "irq_flag", int'(irq_flag), int'(ef));
        check(req, "fill_upper", int'(fill_upper), int'(eh & split_mode));
        for (int a = 0; a < 16; a++) begin
            rd_addr = 4'(a);
            #0.1;
            check(req, $sformatf("loc %0d", a), int'(rd_data), int'(em[a]));
        end
    endtask

    task automatic cyc(bit v, logic [9:0] c, bit clr);
        int addr;
        res_valid = v; res_code = c; irq_clear = clr;
        @(posedge clk);
        if (v) begin
            addr = split_mode ? ((int'(eh) << 3) | (ep & 7)) : ep;
            em[addr] = fmtw(c, fmt_sel);
            if (ec >= int'(seq_per_irq)) begin
                ec = 0;
                if (split_mode) begin eh = ~eh; ep = int'(eh) << 3; end
                else begin eh = 0; ep = 0; end
                ef = 1;
            end else begin
                ec++;
                ep = split_mode ? ((ep & 8) | ((ep + 1) & 7)) : ((ep + 1) & 15);
                if (clr) ef = 0;
            end
        end else if (clr) ef = 0;
        @(negedge clk);
        res_valid = 0; irq_clear = 0;
    endtask

    initial begin
        #(200000 * 5.0);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [9:0] corner [4];
        void'($urandom(32'd1234));
        foreach (em[i]) em[i] = '0;
        corner[0] = 10'h000; corner[1] = 10'h200; corner[2] = 10'h3FF; corner[3] = 10'h1FF;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk_all("R1");

        // R2..R5: each format on corner codes, N=0 so every write hits location 0
        for (int f = 0; f < 4; f++) begin
            fmt_sel = 2'(f);
            for (int k = 0; k < 4; k++) begin
                cyc(1, corner[k], 0);
                case (f)
                    0: chk_all("R2");
                    1: chk_all("R3");
                    2: chk_all("R4");
                    default: chk_all("R5");
                endcase
            end
        end
        // R10: event and clear together keep the flag; plain clear drops it
        cyc(1, 10'h155, 1); chk_all("R10");
        cyc(0, 10'h0AA, 1); chk_all("R10");
        cyc(0, 10'h0AA, 0); chk_all("R10");

        // R6/R7: single mode, 16 per interrupt
        seq_per_irq = 4'd15; fmt_sel = 2'd0;
        for (int i = 0; i < 16; i++) begin
            cyc(1, 10'($urandom), 0);
            chk_all(i == 15 ? "R6" : "R7");
        end
        cyc(1, 10'h3A5, 1); chk_all("R7");   // goes to location 0 again

        // R8: split mode, 8 per interrupt, watch halves swap
        seq_per_irq = 4'd7; split_mode = 1;
        for (int i = 0; i < 40; i++) begin
            cyc(1, 10'($urandom), (i % 9) == 0);
            chk_all("R8");
        end
        // R9: split mode with 12 per interrupt wraps inside a half
        seq_per_irq = 4'd11;
        for (int i = 0; i < 30; i++) begin
            cyc(1, 10'($urandom), 0);
            chk_all("R9");
        end
        // R11: no valid, changing data
        for (int i = 0; i < 6; i++) begin
            cyc(0, 10'($urandom), 0);
            chk_all("R11");
        end
        // Random mix
        for (int seg = 0; seg < 30; seg++) begin
            split_mode  = 1'($urandom);
            seq_per_irq = 4'($urandom);
            for (int i = 0; i < 25; i++) begin
                fmt_sel = 2'($urandom);
                cyc(($urandom % 4) != 0, 10'($urandom), ($urandom % 8) == 0);
                chk_all("R6");
            end
        end
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule